// File: doc/BRIEF.md
# Strap-Configured Management Address Decoder

This block is the target-side address decoder and indirect access engine of a management target that carries several internal register devices behind one clause-22 management bus. The serial frame is already deserialised upstream: the block sees a parallel host port carrying a 5-bit bus address, a 5-bit register number and 16-bit data. Downstream it drives an internal bus that selects an internal device and register and transfers one 16-bit word. That bus answers combinationally in the same cycle.

Four address strap pins (the upper four bits of the bus address; bit 0 is always zero) and a dual-variant strap are captured once after reset. Together they choose one of three modes. In single mode every bus address passes straight through to the internal device with the same number. In dual mode the upper strap bit picks a 16-address half of the bus, so two targets can share it. In multi mode the block answers only a command and a data register at its strapped even address. Internal accesses run through these two registers, and a self-clearing busy bit lets the host poll for completion.

Top module: `mgmt_addr_decoder`

## Requirements
- R1: The straps are captured on the first rising clock edge after reset is released, and later strap changes have no effect. A high dual strap selects dual mode. Otherwise an all-zero address strap selects single mode, and any other value selects multi mode.
- R2: In single mode a host access to bus address A, register G reaches internal device A, register G. This holds for all 32 addresses.
- R3: In dual mode the base address is 16 times the upper address strap bit. Bus addresses base to base+15 reach internal device (address − base). Any other address reads 16'hFFFF and a write there causes no internal access.
- R4: In multi mode only bus address {strap,0} is answered: register 0 is the command register and register 1 is the data register. Reads of other registers or addresses return 16'hFFFF. Writes to them cause no internal access and change nothing.
- R5: The command word layout is: bit 15 busy, bit 12 clause-22 flag, bits 11:10 opcode (01 write, 10 read), bits 9:5 internal device, bits 4:0 internal register. Bits 14:13 read as zero. A command write with bit 15, bit 12 and a valid opcode starts an access and sets busy, and the stored fields read back.
- R6: A command write that lacks bit 15 or bit 12, or carries opcode 00 or 11, leaves busy clear and causes no internal access.
- R7: An indirect write transfers the data register contents to the selected internal device and register.
- R8: An indirect read loads the selected internal word into the data register before busy clears.
- R9: With latency input L (0 to 7), busy reads as set for exactly L+1 consecutive cycles after the command write. The value of L is taken when the command starts.
- R10: While busy is set, writes to the command register and to the data register are ignored.
- R11: A host read returns its data on host_rdata_o in the cycle after the request, with host_rvalid_o high for that cycle.
- R12: After reset, busy is clear, the data register reads zero and no internal access is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_strap_i | input | 4 | Address strap, upper four bus address bits |
| dual_strap_i | input | 1 | Dual-variant strap |
| lat_i | input | 3 | Internal access latency minus one |
| host_req_i | input | 1 | Host access strobe |
| host_we_i | input | 1 | Host write when high, read when low |
| host_phy_i | input | 5 | Bus address of the access |
| host_reg_i | input | 5 | Register number of the access |
| host_wdata_i | input | 16 | Host write data |
| host_rvalid_o | output | 1 | Read data valid |
| host_rdata_o | output | 16 | Read data |
| dev_req_o | output | 1 | Internal access strobe |
| dev_we_o | output | 1 | Internal write |
| dev_sel_o | output | 5 | Internal device number |
| dev_reg_o | output | 5 | Internal register number |
| dev_wdata_o | output | 16 | Internal write data |
| dev_rdata_i | input | 16 | Internal read data, same cycle |

## Verification
The bench fills the internal device model so that every word encodes its own device and register number. A misrouted address or a register swap therefore shows up as a wrong value rather than a plausible one. Each mode is entered through its own reset. In single mode the accesses go to the lowest, a middle and the highest address. In dual mode both straps of the upper bit are tried, with accesses just inside and just outside the answered half, which separates an off-by-base fault from a wrong half. In multi mode the bench polls busy at latencies 0 and 7 to pin down its exact width. It also overlaps command and data writes with a running access to tell ignored writes from accepted ones, sends malformed commands, and changes the strap after reset.

// File: rtl/mgmt_dec_pkg.sv
`timescale 1ns/1ps
package mgmt_dec_pkg;
  localparam int unsigned STRAP_W = 4;
  localparam int unsigned ADDR_W  = STRAP_W + 1;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned LAT_W   = 3;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_MULTI  = 2'd1,
    MODE_DUAL   = 2'd2
  } dec_mode_e;

  typedef enum logic [1:0] {
    HIT_NONE   = 2'd0,
    HIT_DIRECT = 2'd1,
    HIT_CMD    = 2'd2,
    HIT_DATA   = 2'd3
  } hit_e;

  localparam int unsigned CMD_BUSY_BIT = 15;
  localparam int unsigned CMD_C22_BIT  = 12;
  localparam int unsigned CMD_OP_LSB   = 10;
  localparam int unsigned CMD_DEV_LSB  = 5;
  localparam logic [1:0]  OP_WR        = 2'b01;
  localparam logic [1:0]  OP_RD        = 2'b10;
  localparam logic [ADDR_W-1:0] REG_CMD  = '0;
  localparam logic [ADDR_W-1:0] REG_DATA = ADDR_W'(1);
endpackage

// File: rtl/mgmt_mode_cfg.sv
`timescale 1ns/1ps
module mgmt_mode_cfg
  import mgmt_dec_pkg::*;
#(
  parameter int unsigned STRAP_WIDTH = STRAP_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [STRAP_WIDTH-1:0] addr_strap_i,
  input  logic                   dual_strap_i,
  output logic [STRAP_WIDTH-1:0] strap_o,
  output dec_mode_e              mode_o,
  output logic                   cfg_done_o
);
  logic [STRAP_WIDTH-1:0] strap_q;
  logic                   dual_q;
  logic                   done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= '0;
      dual_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (!done_q) begin
      strap_q <= addr_strap_i;
      dual_q  <= dual_strap_i;
      done_q  <= 1'b1;
    end
  end

  always_comb begin
    if (dual_q)            mode_o = MODE_DUAL;
    else if (strap_q == '0) mode_o = MODE_SINGLE;
    else                   mode_o = MODE_MULTI;
  end

  assign strap_o    = strap_q;
  assign cfg_done_o = done_q;

  // R1
  strap_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> (done_q && $stable(strap_q) && $stable(dual_q)));
endmodule

// File: rtl/mgmt_host_decode.sv
`timescale 1ns/1ps
module mgmt_host_decode
  import mgmt_dec_pkg::*;
#(
  parameter int unsigned STRAP_WIDTH = STRAP_W,
  localparam int unsigned AW = STRAP_WIDTH + 1
) (
  input  dec_mode_e              mode_i,
  input  logic [STRAP_WIDTH-1:0] strap_i,
  input  logic                   cfg_done_i,
  input  logic [AW-1:0]          phy_i,
  input  logic [AW-1:0]          reg_i,
  output hit_e                   hit_o,
  output logic [AW-1:0]          dev_sel_o
);
  logic [AW-1:0] own_addr;
  logic          half_hit;

  assign own_addr = {strap_i, 1'b0};
  assign half_hit = (phy_i[AW-1] == strap_i[STRAP_WIDTH-1]);

  always_comb begin
    hit_o     = HIT_NONE;
    dev_sel_o = phy_i;
    if (cfg_done_i) begin
      unique case (mode_i)
        MODE_SINGLE: hit_o = HIT_DIRECT;
        MODE_DUAL: begin
          dev_sel_o = {1'b0, phy_i[AW-2:0]};
          if (half_hit) hit_o = HIT_DIRECT;
        end
        MODE_MULTI: begin
          if (phy_i == own_addr) begin
            if (reg_i == REG_CMD)       hit_o = HIT_CMD;
            else if (reg_i == REG_DATA) hit_o = HIT_DATA;
          end
        end
        default: hit_o = HIT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mgmt_indirect_engine.sv
`timescale 1ns/1ps
module mgmt_indirect_engine
  import mgmt_dec_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned LW   = LAT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  logic          data_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [LW-1:0] lat_i,
  input  logic [DW-1:0] dev_rdata_i,
  output logic [DW-1:0] cmd_o,
  output logic [DW-1:0] data_o,
  output logic          busy_o,
  output logic          dev_req_o,
  output logic          dev_we_o,
  output logic [AW-1:0] dev_sel_o,
  output logic [AW-1:0] dev_reg_o,
  output logic [DW-1:0] dev_wdata_o
);
  logic          busy_q;
  logic [LW-1:0] cnt_q;
  logic          c22_q;
  logic [1:0]    op_q;
  logic [AW-1:0] dev_q;
  logic [AW-1:0] reg_q;
  logic [DW-1:0] data_q;
  logic [1:0]    op_in;
  logic          op_ok;
  logic          start;
  logic          fire;

  assign op_in = wdata_i[CMD_OP_LSB +: 2];
  assign op_ok = (op_in == OP_WR) || (op_in == OP_RD);
  assign start = cmd_wr_i && !busy_q && wdata_i[CMD_BUSY_BIT]
              && wdata_i[CMD_C22_BIT] && op_ok;
  assign fire  = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      c22_q  <= 1'b0;
      op_q   <= '0;
      dev_q  <= '0;
      reg_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= lat_i;
      c22_q  <= 1'b1;
      op_q   <= op_in;
      dev_q  <= wdata_i[CMD_DEV_LSB +: AW];
      reg_q  <= wdata_i[AW-1:0];
    end else if (busy_q) begin
      if (cnt_q != '0) cnt_q  <= cnt_q - 1'b1;
      else             busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     data_q <= '0;
    else if (fire && op_q == OP_RD)  data_q <= dev_rdata_i;
    else if (data_wr_i && !busy_q)   data_q <= wdata_i;
  end

  always_comb begin
    cmd_o = '0;
    cmd_o[CMD_BUSY_BIT]        = busy_q;
    cmd_o[CMD_C22_BIT]         = c22_q;
    cmd_o[CMD_OP_LSB +: 2]     = op_q;
    cmd_o[CMD_DEV_LSB +: AW]   = dev_q;
    cmd_o[AW-1:0]              = reg_q;
  end

  assign data_o      = data_q;
  assign busy_o      = busy_q;
  assign dev_req_o   = fire;
  assign dev_we_o    = (op_q == OP_WR);
  assign dev_sel_o   = dev_q;
  assign dev_reg_o   = reg_q;
  assign dev_wdata_o = data_q;

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q);
  // R8
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !busy_q);
  // R8
  rd_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_req_o && !dev_we_o) |=> (data_q == $past(dev_rdata_i)));
  // R10
  busy_cmd_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cmd_wr_i) |=> ($stable(dev_q) && $stable(reg_q) && $stable(op_q)));
  // R10
  busy_data_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fire && data_wr_i) |=> $stable(data_q));
  // R6
  no_bad_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && cmd_wr_i && !wdata_i[CMD_BUSY_BIT]) |=> !busy_q);
endmodule

// File: rtl/mgmt_addr_decoder.sv
`timescale 1ns/1ps
module mgmt_addr_decoder
  import mgmt_dec_pkg::*;
#(
  parameter int unsigned STRAP_WIDTH = STRAP_W,
  parameter int unsigned DW          = DATA_W,
  parameter int unsigned LW          = LAT_W,
  localparam int unsigned AW         = STRAP_WIDTH + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [STRAP_WIDTH-1:0] addr_strap_i,
  input  logic                   dual_strap_i,
  input  logic [LW-1:0]          lat_i,
  input  logic                   host_req_i,
  input  logic                   host_we_i,
  input  logic [AW-1:0]          host_phy_i,
  input  logic [AW-1:0]          host_reg_i,
  input  logic [DW-1:0]          host_wdata_i,
  output logic                   host_rvalid_o,
  output logic [DW-1:0]          host_rdata_o,
  output logic                   dev_req_o,
  output logic                   dev_we_o,
  output logic [AW-1:0]          dev_sel_o,
  output logic [AW-1:0]          dev_reg_o,
  output logic [DW-1:0]          dev_wdata_o,
  input  logic [DW-1:0]          dev_rdata_i
);
  dec_mode_e              mode;
  logic [STRAP_WIDTH-1:0] strap;
  logic                   cfg_done;
  hit_e                   hit;
  logic [AW-1:0]          dir_sel;
  logic [DW-1:0]          cmd_word;
  logic [DW-1:0]          data_word;
  logic                   eng_busy;
  logic                   eng_req, eng_we;
  logic [AW-1:0]          eng_sel, eng_reg;
  logic [DW-1:0]          eng_wdata;
  logic                   rd_req;
  logic                   rvalid_q;
  logic [DW-1:0]          rdata_q;

  mgmt_mode_cfg #(.STRAP_WIDTH(STRAP_WIDTH)) i_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_strap_i (addr_strap_i),
    .dual_strap_i (dual_strap_i),
    .strap_o      (strap),
    .mode_o       (mode),
    .cfg_done_o   (cfg_done)
  );

  mgmt_host_decode #(.STRAP_WIDTH(STRAP_WIDTH)) i_dec (
    .mode_i     (mode),
    .strap_i    (strap),
    .cfg_done_i (cfg_done),
    .phy_i      (host_phy_i),
    .reg_i      (host_reg_i),
    .hit_o      (hit),
    .dev_sel_o  (dir_sel)
  );

  mgmt_indirect_engine #(.AW(AW), .DW(DW), .LW(LW)) i_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_wr_i    (host_req_i && host_we_i && hit == HIT_CMD),
    .data_wr_i   (host_req_i && host_we_i && hit == HIT_DATA),
    .wdata_i     (host_wdata_i),
    .lat_i       (lat_i),
    .dev_rdata_i (dev_rdata_i),
    .cmd_o       (cmd_word),
    .data_o      (data_word),
    .busy_o      (eng_busy),
    .dev_req_o   (eng_req),
    .dev_we_o    (eng_we),
    .dev_sel_o   (eng_sel),
    .dev_reg_o   (eng_reg),
    .dev_wdata_o (eng_wdata)
  );

  always_comb begin
    if (mode == MODE_MULTI) begin
      dev_req_o   = eng_req;
      dev_we_o    = eng_we;
      dev_sel_o   = eng_sel;
      dev_reg_o   = eng_reg;
      dev_wdata_o = eng_wdata;
    end else begin
      dev_req_o   = host_req_i && (hit == HIT_DIRECT);
      dev_we_o    = host_we_i;
      dev_sel_o   = dir_sel;
      dev_reg_o   = host_reg_i;
      dev_wdata_o = host_wdata_i;
    end
  end

  assign rd_req = host_req_i && !host_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) begin
        unique case (hit)
          HIT_DIRECT: rdata_q <= dev_rdata_i;
          HIT_CMD:    rdata_q <= cmd_word;
          HIT_DATA:   rdata_q <= data_word;
          default:    rdata_q <= '1;
        endcase
      end
    end
  end

  assign host_rvalid_o = rvalid_q;
  assign host_rdata_o  = rdata_q;

  // R11
  miss_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && hit == HIT_NONE) |=> (host_rvalid_o && host_rdata_o == '1));
  // R4
  multi_no_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_MULTI && dev_req_o) |-> eng_busy);
  // R12
  cold_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_done |-> !dev_req_o);
endmodule

// File: tb/test_mgmt_addr_decoder.sv
`timescale 1ns/1ps
module test_mgmt_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr_strap = '0;
  logic        dual_strap = 1'b0;
  logic [2:0]  lat = '0;
  logic        h_req = 1'b0, h_we = 1'b0;
  logic [4:0]  h_phy = '0, h_reg = '0;
  logic [15:0] h_wdata = '0;
  logic        h_rvalid;
  logic [15:0] h_rdata;
  logic        d_req, d_we;
  logic [4:0]  d_sel, d_reg;
  logic [15:0] d_wdata, d_rdata;

  int total = 0, bad = 0, dev_wr_cnt = 0;
  bit finished = 0;
  logic [15:0] mem [32][32];

  always #4 clk = ~clk;  // 125 MHz

  mgmt_addr_decoder i_mgmt_addr_decoder (
    .clk_i(clk), .rst_ni(rst_n), .addr_strap_i(addr_strap), .dual_strap_i(dual_strap),
    .lat_i(lat), .host_req_i(h_req), .host_we_i(h_we), .host_phy_i(h_phy),
    .host_reg_i(h_reg), .host_wdata_i(h_wdata), .host_rvalid_o(h_rvalid),
    .host_rdata_o(h_rdata), .dev_req_o(d_req), .dev_we_o(d_we), .dev_sel_o(d_sel),
    .dev_reg_o(d_reg), .dev_wdata_o(d_wdata), .dev_rdata_i(d_rdata)
  );

  assign d_rdata = mem[d_sel][d_reg];
  always @(posedge clk) if (d_req && d_we) begin
    mem[d_sel][d_reg] <= d_wdata;
    dev_wr_cnt <= dev_wr_cnt + 1;
  end

  function automatic logic [15:0] pat(int d, int r);
    return 16'((d << 11) | (r << 6) | 6'h15);
  endfunction

  function automatic logic [15:0] mk_cmd(logic [1:0] op, logic [4:0] d, logic [4:0] r);
    return {1'b1, 2'b00, 1'b1, op, d, r};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int d = 0; d < 32; d++)
      for (int r = 0; r < 32; r++) mem[d][r] = pat(d, r);
  endtask

  task automatic do_reset(logic [3:0] s, logic dl);
    @(negedge clk);
    rst_n = 1'b0; h_req = 1'b0; addr_strap = s; dual_strap = dl;
    fill_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // called at a negedge, returns at the next negedge
  task automatic host_wr(logic [4:0] p, logic [4:0] r, logic [15:0] v);
    h_req = 1'b1; h_we = 1'b1; h_phy = p; h_reg = r; h_wdata = v;
    @(negedge clk);
    h_req = 1'b0; h_we = 1'b0;
  endtask

  task automatic host_rd(logic [4:0] p, logic [4:0] r, output logic [15:0] v);
    h_req = 1'b1; h_we = 1'b0; h_phy = p; h_reg = r;
    @(negedge clk);
    h_req = 1'b0;
    v = h_rdata;
    total++;
    if (h_rvalid !== 1'b1) begin
      bad++;
      $display("FAIL R11 rvalid actual=%b expected=1", h_rvalid);
    end
  endtask

  task automatic poll_idle(logic [4:0] p, output int n);
    logic [15:0] v;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      host_rd(p, 5'd0, v);
      if (!v[15]) break;
      n++;
    end
  endtask

  task automatic t_single();
    logic [15:0] v;
    int w0;
    do_reset(4'h0, 1'b0);
    host_rd(5'd0, 5'd0, v);   chk("R2 addr0", v, pat(0, 0));
    host_rd(5'd13, 5'd7, v);  chk("R2 addr13", v, pat(13, 7));
    host_rd(5'd31, 5'd31, v); chk("R2 addr31", v, pat(31, 31));
    w0 = dev_wr_cnt;
    host_wr(5'd31, 5'd2, 16'hBEEF);
    chk("R2 direct write", mem[31][2], 16'hBEEF);
    chk("R2 write count", 16'(dev_wr_cnt - w0), 16'd1);
    @(negedge clk);
    chk("R11 rvalid low idle", {15'd0, h_rvalid}, 16'd0);
  endtask

  task automatic t_dual_hi();
    logic [15:0] v;
    int w0;
    do_reset(4'h8, 1'b1);
    host_rd(5'd16, 5'd4, v); chk("R3 hi base", v, pat(0, 4));
    host_rd(5'd31, 5'd9, v); chk("R3 hi top", v, pat(15, 9));
    host_rd(5'd15, 5'd0, v); chk("R3 hi miss", v, 16'hFFFF);
    w0 = dev_wr_cnt;
    host_wr(5'd2, 5'd1, 16'h1234);
    chk("R3 miss write no access", 16'(dev_wr_cnt - w0), 16'd0);
    host_wr(5'd19, 5'd1, 16'h4321);
    chk("R3 hi write dev3", mem[3][1], 16'h4321);
  endtask

  task automatic t_dual_lo();
    logic [15:0] v;
    do_reset(4'h6, 1'b1);  // dual wins over nonzero strap, upper bit 0
    host_rd(5'd15, 5'd3, v); chk("R1 R3 lo top", v, pat(15, 3));
    host_rd(5'd16, 5'd3, v); chk("R3 lo miss", v, 16'hFFFF);
  endtask

  task automatic t_multi_basic();
    logic [15:0] v;
    int w0;
    do_reset(4'h3, 1'b0);  // own address 6
    host_rd(5'd6, 5'd0, v); chk("R12 cmd reset", v, 16'h0000);
    host_rd(5'd6, 5'd1, v); chk("R12 data reset", v, 16'h0000);
    host_rd(5'd6, 5'd2, v); chk("R4 other reg", v, 16'hFFFF);
    host_rd(5'd7, 5'd0, v); chk("R4 odd addr", v, 16'hFFFF);
    host_rd(5'd0, 5'd0, v); chk("R4 addr0", v, 16'hFFFF);
    w0 = dev_wr_cnt;
    host_wr(5'd7, 5'd1, 16'hAAAA);
    host_wr(5'd6, 5'd5, 16'hAAAA);
    host_rd(5'd6, 5'd1, v); chk("R4 miss write keeps data", v, 16'h0000);
    chk("R4 miss write no access", 16'(dev_wr_cnt - w0), 16'd0);
  endtask

  task automatic t_multi_rw();
    logic [15:0] v;
    int n;
    lat = 3'd2;
    host_wr(5'd6, 5'd0, mk_cmd(2'b10, 5'd9, 5'd17));
    host_rd(5'd6, 5'd0, v); chk("R5 cmd readback", v, mk_cmd(2'b10, 5'd9, 5'd17));
    poll_idle(5'd6, n);
    host_rd(5'd6, 5'd1, v); chk("R8 indirect read", v, pat(9, 17));
    host_rd(5'd6, 5'd0, v); chk("R5 busy cleared", v, {1'b0, 2'b00, 1'b1, 2'b10, 5'd9, 5'd17});
    host_wr(5'd6, 5'd1, 16'hC0DE);
    host_wr(5'd6, 5'd0, mk_cmd(2'b01, 5'd30, 5'd4));
    poll_idle(5'd6, n);
    chk("R7 indirect write", mem[30][4], 16'hC0DE);
  endtask

  task automatic t_latency();
    int n;
    lat = 3'd0;
    host_wr(5'd6, 5'd0, mk_cmd(2'b10, 5'd1, 5'd1));
    poll_idle(5'd6, n); chk("R9 latency 1", 16'(n), 16'd1);
    lat = 3'd7;
    host_wr(5'd6, 5'd0, mk_cmd(2'b10, 5'd1, 5'd1));
    lat = 3'd0;  // must not affect the running access
    poll_idle(5'd6, n); chk("R9 latency 8", 16'(n), 16'd8);
  endtask

  task automatic t_busy_lock();
    logic [15:0] v;
    int n;
    lat = 3'd5;
    host_wr(5'd6, 5'd1, 16'h5555);
    host_wr(5'd6, 5'd0, mk_cmd(2'b01, 5'd12, 5'd8));
    host_wr(5'd6, 5'd1, 16'h6666);
    host_wr(5'd6, 5'd0, mk_cmd(2'b01, 5'd20, 5'd20));
    poll_idle(5'd6, n);
    chk("R10 data locked", mem[12][8], 16'h5555);
    chk("R10 cmd locked", mem[20][20], pat(20, 20));
    host_rd(5'd6, 5'd0, v); chk("R10 cmd fields", v, {1'b0, 2'b00, 1'b1, 2'b01, 5'd12, 5'd8});
    host_rd(5'd6, 5'd1, v); chk("R10 data reg", v, 16'h5555);
  endtask

  task automatic t_bad_cmd();
    logic [15:0] v;
    int w0;
    w0 = dev_wr_cnt;
    lat = 3'd3;
    host_wr(5'd6, 5'd0, {1'b1, 2'b00, 1'b1, 2'b00, 5'd2, 5'd2});
    host_rd(5'd6, 5'd0, v); chk("R6 op00 no busy", {15'd0, v[15]}, 16'd0);
    host_wr(5'd6, 5'd0, {1'b1, 2'b00, 1'b0, 2'b01, 5'd2, 5'd2});
    host_rd(5'd6, 5'd0, v); chk("R6 no c22 no busy", {15'd0, v[15]}, 16'd0);
    host_wr(5'd6, 5'd0, {1'b0, 2'b00, 1'b1, 2'b01, 5'd2, 5'd2});
    host_rd(5'd6, 5'd0, v); chk("R6 no busy bit", {15'd0, v[15]}, 16'd0);
    host_wr(5'd6, 5'd0, {1'b1, 2'b00, 1'b1, 2'b11, 5'd2, 5'd2});
    repeat (10) @(negedge clk);
    chk("R6 no access", 16'(dev_wr_cnt - w0), 16'd0);
    chk("R6 mem intact", mem[2][2], pat(2, 2));
  endtask

  task automatic t_strap_late();
    logic [15:0] v;
    addr_strap = 4'h0;
    dual_strap = 1'b0;
    @(negedge clk);
    host_rd(5'd5, 5'd5, v); chk("R1 late strap ignored", v, 16'hFFFF);
    host_rd(5'd6, 5'd1, v); chk("R1 still multi", v, 16'h5555);
  endtask

  initial begin
    do_reset(4'h0, 1'b0);
    chk("R12 rvalid reset", {15'd0, h_rvalid}, 16'd0);
    chk("R12 no dev req", {15'd0, d_req}, 16'd0);
    t_single();
    t_dual_hi();
    t_dual_lo();
    t_multi_basic();
    t_multi_rw();
    t_latency();
    t_busy_lock();
    t_bad_cmd();
    t_strap_late();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule